// File: doc/BRIEF.md
# Serial Synthesiser Programming Interface

This block takes program words for a dual PLL synthesiser from a three-wire bus (serial data, serial clock, strobe) and sorts them into parallel control registers. These registers feed the divider, fractional accumulator and charge-pump control logic. A word is shifted in with its least significant bit first. It is loaded when the strobe rises. The leading header bits select where the word goes. A word length that does not match the expected length for that header, or a header that has no assignment, causes the word to be dropped.

There are four kinds of word. A frequency word has a leading 0. It is 24 bits long, or 32 bits long when the stored long-form flag is set, and the 32-bit form also carries a current-scale byte. A staging word (header 1000) holds prescaler and gain settings. These settings wait in a holding register and move to the working registers only when the next frequency word arrives, so several settings change together. An auxiliary word (1001) sets the auxiliary divider. A reference word (1010) sets the reference divider, the tap selects, the disables, the fractional modulus and the long-form flag. While the strobe stays high after an accepted frequency word, a speed-up output tells the loop to widen its bandwidth.

All bus inputs are sampled by the system clock, which must be much faster than the serial clock. Register outputs change on the second system clock edge after the strobe input rises.

Top module: `sp_prog_if`

## Requirements
- R1: After a synchronous active-low reset, every register output is 0 and `speed_up` is 0. This includes `long_word`, so frequency words start out as 24 bits.
- R2: Bits are taken on rising edges of `bus_clk` while `bus_strobe` is low, least significant bit first. A 24-bit reference word (bits 23:20 = 1010) loads `ref_div` from bits 19:8, `main_ref_sel` from 7:6, `main_off` from 5, `aux_ref_sel` from 4:3, `aux_off` from 2, `frac_mod8` from 1 and `long_word` from 0.
- R3: A 24-bit auxiliary word (bits 23:20 = 1001) loads `aux_div` from bits 19:8. Bits 7:0 are ignored.
- R4: When `long_word` is 0, a 24-bit word with bit 23 = 0 loads `frac_inc` from bits 22:20, `main_cnt1` from 19:8 and `main_cnt2` from 7:0.
- R5: When `long_word` is 1, the frequency word is 32 bits long with bit 31 = 0. It loads `frac_inc` from 30:28, `main_cnt1` from 27:16, `main_cnt2` from 15:8 and `cur_scale` from 7:0.
- R6: A 24-bit staging word (bits 23:20 = 1000) holds `cnt_sum4` from 19:16, `cur_scale` from 15:8, `int_gain` from 7:4, `prop_gain` from 3:2 and `modulus_cnt` from 1:0 without changing any output. These values reach the outputs together with the next accepted frequency word. If that word is a 32-bit word, its own scale byte takes precedence for `cur_scale`.
- R7: `speed_up` rises two clock cycles after a strobe rise that loads a frequency word. It stays high until two cycles after the strobe falls. It never rises for other words or for discarded words.
- R8: `bus_clk` edges while the strobe is high shift nothing and count nothing.
- R9: If the strobe rises after a number of bits different from the length for that word type, the word is discarded and no output changes.
- R10: Headers 1011 and 11xx are discarded and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock |
| bus_data | input | 1 | Serial bus data |
| bus_strobe | input | 1 | Load strobe, active high |
| frac_inc | output | 3 | Fractional increment |
| main_cnt1 | output | 12 | Main divider first-modulus count |
| main_cnt2 | output | 8 | Main divider second-modulus count |
| cur_scale | output | 8 | Charge-pump current scale |
| cnt_sum4 | output | 4 | Cumulative count up to the fourth modulus |
| int_gain | output | 4 | Integral pump acceleration |
| prop_gain | output | 2 | Proportional pump acceleration |
| modulus_cnt | output | 2 | Prescaler modulus count select |
| aux_div | output | 12 | Auxiliary divider value |
| ref_div | output | 12 | Reference divider value |
| main_ref_sel | output | 2 | Main reference tap select |
| main_off | output | 1 | Main synthesiser disable |
| aux_ref_sel | output | 2 | Auxiliary reference tap select |
| aux_off | output | 1 | Auxiliary synthesiser disable |
| frac_mod8 | output | 1 | Fractional modulus (1 = eight, 0 = five) |
| long_word | output | 1 | Frequency word is 32 bits |
| speed_up | output | 1 | Loop speed-up request |

## Verification
The assertions check on every cycle that the bit counter stays at zero and stays bounded while the strobe is high. They also check that a decoded word type appears only on a strobe rise, that a staging word leaves the working outputs unchanged, that the auxiliary and reference registers change only for their own word types, and that `speed_up` is high only after a cycle with the strobe high. The bench scenarios show the rest: field placement, the effect of the long-form flag on word length, a staged set of values arriving together with a later frequency word, the 32-bit scale byte taking precedence over the staged one, and discarding for wrong lengths and unassigned headers.

// File: rtl/sp_prog_pkg.sv
// Shared constants and types for the serial programming interface.
// Assumes a fixed word format: 4-bit headers and 24- or 32-bit words.
package sp_prog_pkg;
    localparam int SHORT_W = 24;
    localparam int LONG_W  = 32;
    localparam int HDR_W   = 4;
    localparam int NF_W    = 3;
    localparam int N1_W    = 12;
    localparam int N2_W    = 8;
    localparam int CN_W    = 8;
    localparam int N4_W    = 4;
    localparam int K_W     = 4;
    localparam int L_W     = 2;
    localparam int P_W     = 2;
    localparam int NA_W    = 12;
    localparam int NR_W    = 12;
    localparam int SEL_W   = 2;
    localparam int CNT_SAT = LONG_W + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    localparam logic [HDR_W-1:0] HDR_STAGE = 4'b1000;
    localparam logic [HDR_W-1:0] HDR_AUX   = 4'b1001;
    localparam logic [HDR_W-1:0] HDR_REF   = 4'b1010;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_FREQ,
        WK_STAGE,
        WK_AUX,
        WK_REF
    } word_kind_e;

    // Fields parsed out of the shift register (valid per word kind)
    typedef struct packed {
        logic             is_long;
        logic [NF_W-1:0]  nf;
        logic [N1_W-1:0]  n1;
        logic [N2_W-1:0]  n2;
        logic [CN_W-1:0]  cn_long;
        logic [N4_W-1:0]  n234;
        logic [CN_W-1:0]  cn_stage;
        logic [K_W-1:0]   k;
        logic [L_W-1:0]   l;
        logic [P_W-1:0]   p;
        logic [NA_W-1:0]  na;
        logic [NR_W-1:0]  nr;
        logic [SEL_W-1:0] msel;
        logic             mdis;
        logic [SEL_W-1:0] asel;
        logic             adis;
        logic             fmod;
        logic             long_sel;
    } word_fields_t;

    // Working register set driven to the outputs
    typedef struct packed {
        logic [NF_W-1:0]  nf;
        logic [N1_W-1:0]  n1;
        logic [N2_W-1:0]  n2;
        logic [CN_W-1:0]  cn;
        logic [N4_W-1:0]  n234;
        logic [K_W-1:0]   k;
        logic [L_W-1:0]   l;
        logic [P_W-1:0]   p;
        logic [NA_W-1:0]  na;
        logic [NR_W-1:0]  nr;
        logic [SEL_W-1:0] msel;
        logic             mdis;
        logic [SEL_W-1:0] asel;
        logic             adis;
        logic             fmod;
        logic             long_sel;
    } work_regs_t;
endpackage

// File: rtl/sp_bus_sync.sv
// Samples the three bus wires into the system clock domain and produces
// edge pulses. Assumes the bus is slow against clk and is held steady
// for at least two clk cycles around every transition.
module sp_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_data,
    input  logic bus_strobe,
    output logic data_q,
    output logic sclk_rise,
    output logic strb_lvl,
    output logic strb_rise
);
    logic sclk_q, sclk_d, strb_q, strb_d;

    // Register the wires and keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            strb_q <= 1'b0;
            strb_d <= 1'b0;
            data_q <= 1'b0;
        end else begin
            sclk_q <= bus_clk;
            sclk_d <= sclk_q;
            strb_q <= bus_strobe;
            strb_d <= strb_q;
            data_q <= bus_data;
        end
    end

    // Edge pulses, one clk cycle wide
    always_comb begin
        sclk_rise = sclk_q & ~sclk_d;
        strb_lvl  = strb_q;
        strb_rise = strb_q & ~strb_d;
    end
endmodule

// File: rtl/sp_shift_collect.sv
// Collects serial bits into a top-aligned shift register and counts them.
// Each new bit enters at the top, so the last bit (the word MSB) ends up
// in the highest position regardless of the word length.
module sp_shift_collect #(
    parameter int SR_W  = 32,
    parameter int CNT_W = 6,
    parameter int SAT   = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             data_q,
    input  logic             strb_lvl,
    input  logic             strb_rise,
    output logic [SR_W-1:0]  sr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAT);

    logic shift_en;
    assign shift_en = sclk_rise & ~strb_lvl;

    // Shift right with the new bit entering at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {data_q, sr[SR_W-1:1]};
        end
    end

    // Count bits of the current word, restart after each strobe, saturate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (strb_rise) begin
            cnt <= '0;
        end else if (shift_en && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: no counting while the strobe is high
    a_r8_cnt_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        strb_lvl |=> (cnt == '0));

    // R9: the counter never passes its saturation limit
    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
endmodule

// File: rtl/sp_word_decode.sv
// Classifies the collected word on a strobe rise and splits out its fields.
// Assumes the shift register is top-aligned: a 24-bit word occupies the
// upper 24 positions and a 32-bit word fills the register.
module sp_word_decode
    import sp_prog_pkg::*;
#(
    parameter int SR_W  = LONG_W,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SR_W-1:0]  sr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             eval,
    input  logic             long_sel,
    output word_kind_e       kind,
    output word_fields_t     fld
);
    localparam int TOP  = SR_W - 1;
    localparam int BODY = TOP - HDR_W;
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(LONG_W);

    logic [HDR_W-1:0] hdr;
    logic [CNT_W-1:0] freq_len;
    assign hdr      = sr[TOP -: HDR_W];
    assign freq_len = long_sel ? LEN_L : LEN_S;

    // Field extraction, positions measured down from the register top
    always_comb begin
        fld = '0;
        fld.is_long = long_sel;
        {fld.nf, fld.n1, fld.n2, fld.cn_long} = sr[TOP-1:0];
        {fld.n234, fld.cn_stage, fld.k, fld.l, fld.p} = sr[BODY -: 20];
        fld.na = sr[BODY -: NA_W];
        {fld.nr, fld.msel, fld.mdis, fld.asel, fld.adis, fld.fmod, fld.long_sel}
            = sr[BODY -: 20];
    end

    // Word kind from the header and the bit count, only on a strobe rise
    always_comb begin
        kind = WK_NONE;
        if (eval) begin
            if (!hdr[HDR_W-1]) begin
                if (cnt == freq_len) kind = WK_FREQ;
            end else if (cnt == LEN_S) begin
                case (hdr)
                    HDR_STAGE: kind = WK_STAGE;
                    HDR_AUX:   kind = WK_AUX;
                    HDR_REF:   kind = WK_REF;
                    default:   kind = WK_NONE;
                endcase
            end
        end
    end

    // R10: a word kind is produced only when the strobe rises
    a_r10_kind_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_NONE) |-> eval);
endmodule

// File: rtl/sp_reg_bank.sv
// Working registers, the staging register for the deferred word, and
// the speed-up flag. Assumes kind is non-NONE for one cycle per word.
module sp_reg_bank
    import sp_prog_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  word_kind_e   kind,
    input  word_fields_t fld,
    input  logic         strb_lvl,
    output work_regs_t   work,
    output logic         speed_up
);
    logic [N4_W-1:0] stg_n234;
    logic [CN_W-1:0] stg_cn;
    logic [K_W-1:0]  stg_k;
    logic [L_W-1:0]  stg_l;
    logic [P_W-1:0]  stg_p;
    logic            stg_valid;

    // Hold a staging word until a frequency word commits it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_n234  <= '0;
            stg_cn    <= '0;
            stg_k     <= '0;
            stg_l     <= '0;
            stg_p     <= '0;
            stg_valid <= 1'b0;
        end else if (kind == WK_STAGE) begin
            stg_n234  <= fld.n234;
            stg_cn    <= fld.cn_stage;
            stg_k     <= fld.k;
            stg_l     <= fld.l;
            stg_p     <= fld.p;
            stg_valid <= 1'b1;
        end else if (kind == WK_FREQ) begin
            stg_valid <= 1'b0;
        end
    end

    // Update the working set for the accepted word kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work <= '0;
        end else begin
            case (kind)
                WK_FREQ: begin
                    work.nf <= fld.nf;
                    work.n1 <= fld.n1;
                    work.n2 <= fld.n2;
                    if (stg_valid) begin
                        work.n234 <= stg_n234;
                        work.cn   <= stg_cn;
                        work.k    <= stg_k;
                        work.l    <= stg_l;
                        work.p    <= stg_p;
                    end
                    if (fld.is_long) work.cn <= fld.cn_long;
                end
                WK_AUX: work.na <= fld.na;
                WK_REF: begin
                    work.nr       <= fld.nr;
                    work.msel     <= fld.msel;
                    work.mdis     <= fld.mdis;
                    work.asel     <= fld.asel;
                    work.adis     <= fld.adis;
                    work.fmod     <= fld.fmod;
                    work.long_sel <= fld.long_sel;
                end
                default: ;
            endcase
        end
    end

    // Speed-up: set by a frequency word, held while the strobe stays high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_up <= 1'b0;
        end else if (kind == WK_FREQ) begin
            speed_up <= 1'b1;
        end else if (!strb_lvl) begin
            speed_up <= 1'b0;
        end
    end

    // R6: a staging word leaves the working gain and count fields alone
    a_r6_stage_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_STAGE) |=> ($stable(work.n234) && $stable(work.cn) &&
                                $stable(work.k) && $stable(work.p)));

    // R7: speed-up only follows a cycle with the strobe high
    a_r7_speed_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        speed_up |-> $past(strb_lvl));

    // R3: the auxiliary divider changes only for an auxiliary word
    a_r3_aux_only_own: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_AUX) |=> $stable(work.na));

    // R9: the reference settings change only for a reference word
    a_r9_ref_only_own: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_REF) |=> ($stable(work.nr) && $stable(work.long_sel)));
endmodule

// File: rtl/sp_prog_if.sv
// Top of the serial programming interface: sampler, collector, decoder
// and register bank. Assumes clk is much faster than bus_clk.
module sp_prog_if
    import sp_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_data,
    input  logic              bus_strobe,
    output logic [NF_W-1:0]   frac_inc,
    output logic [N1_W-1:0]   main_cnt1,
    output logic [N2_W-1:0]   main_cnt2,
    output logic [CN_W-1:0]   cur_scale,
    output logic [N4_W-1:0]   cnt_sum4,
    output logic [K_W-1:0]    int_gain,
    output logic [L_W-1:0]    prop_gain,
    output logic [P_W-1:0]    modulus_cnt,
    output logic [NA_W-1:0]   aux_div,
    output logic [NR_W-1:0]   ref_div,
    output logic [SEL_W-1:0]  main_ref_sel,
    output logic              main_off,
    output logic [SEL_W-1:0]  aux_ref_sel,
    output logic              aux_off,
    output logic              frac_mod8,
    output logic              long_word,
    output logic              speed_up
);
    logic              data_q, sclk_rise, strb_lvl, strb_rise;
    logic [LONG_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    word_kind_e        kind;
    word_fields_t      fld;
    work_regs_t        work;

    sp_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_strobe(bus_strobe), .data_q(data_q), .sclk_rise(sclk_rise),
        .strb_lvl(strb_lvl), .strb_rise(strb_rise)
    );

    sp_shift_collect #(.SR_W(LONG_W), .CNT_W(CNT_W), .SAT(CNT_SAT)) u_collect (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .data_q(data_q),
        .strb_lvl(strb_lvl), .strb_rise(strb_rise), .sr(sr), .cnt(cnt)
    );

    sp_word_decode #(.SR_W(LONG_W), .CNT_W(CNT_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .sr(sr), .cnt(cnt), .eval(strb_rise),
        .long_sel(work.long_sel), .kind(kind), .fld(fld)
    );

    sp_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .kind(kind), .fld(fld),
        .strb_lvl(strb_lvl), .work(work), .speed_up(speed_up)
    );

    // Flatten the working set onto the output pins
    always_comb begin
        frac_inc     = work.nf;
        main_cnt1    = work.n1;
        main_cnt2    = work.n2;
        cur_scale    = work.cn;
        cnt_sum4     = work.n234;
        int_gain     = work.k;
        prop_gain    = work.l;
        modulus_cnt  = work.p;
        aux_div      = work.na;
        ref_div      = work.nr;
        main_ref_sel = work.msel;
        main_off     = work.mdis;
        aux_ref_sel  = work.asel;
        aux_off      = work.adis;
        frac_mod8    = work.fmod;
        long_word    = work.long_sel;
    end
endmodule

// File: tb/tb_sp_prog_if.sv
`timescale 1ns/1ps
module tb_sp_prog_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_strobe = 1'b0;

    logic [2:0]  frac_inc;
    logic [11:0] main_cnt1, aux_div, ref_div;
    logic [7:0]  main_cnt2, cur_scale;
    logic [3:0]  cnt_sum4, int_gain;
    logic [1:0]  prop_gain, modulus_cnt, main_ref_sel, aux_ref_sel;
    logic        main_off, aux_off, frac_mod8, long_word, speed_up;

    sp_prog_if dut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_strobe(bus_strobe), .frac_inc(frac_inc), .main_cnt1(main_cnt1),
        .main_cnt2(main_cnt2), .cur_scale(cur_scale), .cnt_sum4(cnt_sum4),
        .int_gain(int_gain), .prop_gain(prop_gain), .modulus_cnt(modulus_cnt),
        .aux_div(aux_div), .ref_div(ref_div), .main_ref_sel(main_ref_sel),
        .main_off(main_off), .aux_ref_sel(aux_ref_sel), .aux_off(aux_off),
        .frac_mod8(frac_mod8), .long_word(long_word), .speed_up(speed_up)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Behavioural model state
    bit          bitq[$];
    logic [2:0]  m_nf;   logic [11:0] m_n1;  logic [7:0] m_n2;  logic [7:0] m_cn;
    logic [3:0]  m_n234; logic [3:0]  m_k;   logic [1:0] m_l;   logic [1:0] m_p;
    logic [11:0] m_na;   logic [11:0] m_nr;  logic [1:0] m_ms;  logic m_md;
    logic [1:0]  m_as;   logic m_ad; logic m_fm; logic m_long; logic m_spd;
    logic        s_valid; logic [3:0] s_n234; logic [7:0] s_cn;
    logic [3:0]  s_k; logic [1:0] s_l; logic [1:0] s_p;

    int    compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    logic [75:0] exp_d1, exp_d2;

    function automatic logic [75:0] pack_model();
        return {m_nf, m_n1, m_n2, m_cn, m_n234, m_k, m_l, m_p, m_na, m_nr,
                m_ms, m_md, m_as, m_ad, m_fm, m_long, m_spd};
    endfunction

    wire [75:0] dut_vec = {frac_inc, main_cnt1, main_cnt2, cur_scale, cnt_sum4,
                           int_gain, prop_gain, modulus_cnt, aux_div, ref_div,
                           main_ref_sel, main_off, aux_ref_sel, aux_off,
                           frac_mod8, long_word, speed_up};

    task automatic model_reset();
        {m_nf, m_n1, m_n2, m_cn, m_n234, m_k, m_l, m_p, m_na, m_nr} = '0;
        {m_ms, m_md, m_as, m_ad, m_fm, m_long, m_spd} = '0;
        {s_valid, s_n234, s_cn, s_k, s_l, s_p} = '0;
        bitq.delete();
    endtask

    // Model reaction to a strobe rise: decide by length first, then header
    task automatic model_strobe();
        int n = bitq.size();
        logic [31:0] w = '0;
        logic [3:0] h = '0;
        foreach (bitq[i]) w[i] = bitq[i];
        if (n >= 4) h = w[n-1 -: 4];
        if (n == (m_long ? 32 : 24) && w[n-1] == 1'b0) begin
            if (s_valid) begin
                m_n234 = s_n234; m_cn = s_cn; m_k = s_k; m_l = s_l; m_p = s_p;
                s_valid = 1'b0;
            end
            if (m_long) {m_nf, m_n1, m_n2, m_cn} = w[30:0];
            else        {m_nf, m_n1, m_n2} = w[22:0];
            m_spd = 1'b1;
        end else if (n == 24 && h == 4'b1000) begin
            {s_n234, s_cn, s_k, s_l, s_p} = w[19:0];
            s_valid = 1'b1;
        end else if (n == 24 && h == 4'b1001) begin
            m_na = w[19:8];
        end else if (n == 24 && h == 4'b1010) begin
            {m_nr, m_ms, m_md, m_as, m_ad, m_fm, m_long} = w[19:0];
        end
        bitq.delete();
    endtask

    // Expected-value pipeline: outputs follow the model by two clk edges
    always @(posedge clk) begin
        exp_d2 <= exp_d1;
        exp_d1 <= pack_model();
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (dut_vec !== exp_d2) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h at %0t", cur_req, dut_vec, exp_d2, $time);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bus_data = v[i]; bus_clk = 1'b0;
            @(negedge clk); bus_clk = 1'b1; bitq.push_back(v[i]);
            @(negedge clk); bus_clk = 1'b0;
        end
    endtask

    task automatic strobe(int hold, int junk);
        @(negedge clk); bus_strobe = 1'b1; model_strobe();
        idle(2);
        for (int j = 0; j < junk; j++) begin
            @(negedge clk); bus_data = 1'b1; bus_clk = 1'b1;
            @(negedge clk); bus_clk = 1'b0;
        end
        idle(hold);
        @(negedge clk); bus_strobe = 1'b0; m_spd = 1'b0;
        idle(4);
    endtask

    function automatic logic [23:0] mk_a(logic [2:0] nf, logic [11:0] n1, logic [7:0] n2);
        return {1'b0, nf, n1, n2};
    endfunction
    function automatic logic [23:0] mk_b(logic [3:0] s4, logic [7:0] cn, logic [3:0] k,
                                         logic [1:0] l, logic [1:0] p);
        return {4'b1000, s4, cn, k, l, p};
    endfunction
    function automatic logic [23:0] mk_c(logic [11:0] na, logic [7:0] pad);
        return {4'b1001, na, pad};
    endfunction
    function automatic logic [23:0] mk_d(logic [11:0] nr, logic [1:0] ms, logic md,
                                         logic [1:0] as, logic ad, logic fm, logic lg);
        return {4'b1010, nr, ms, md, as, ad, fm, lg};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        exp_d1 = '0; exp_d2 = '0;
        idle(5);
        rst_n = 1'b1;
        cur_req = "R1"; idle(10);                                 // R1 reset values
        cur_req = "R2"; shift_bits({8'h0, mk_d(12'hABC, 2'd2, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0)}, 24); strobe(6, 0);
        cur_req = "R3"; shift_bits({8'h0, mk_c(12'h5A3, 8'hC3)}, 24); strobe(6, 0);
        cur_req = "R4"; shift_bits({8'h0, mk_a(3'd3, 12'd51, 8'd25)}, 24); strobe(10, 0);
        cur_req = "R7"; shift_bits({8'h0, mk_a(3'd1, 12'd7, 8'd2)}, 24); strobe(20, 0); // speed-up window
        cur_req = "R6"; shift_bits({8'h0, mk_b(4'd9, 8'h77, 4'd5, 2'd2, 2'd1)}, 24); strobe(6, 0);
        shift_bits({8'h0, mk_c(12'h111, 8'h00)}, 24); strobe(6, 0); // R6 stage still held
        shift_bits({8'h0, mk_a(3'd5, 12'd100, 8'd200)}, 24); strobe(6, 0); // R6 commit
        cur_req = "R5"; shift_bits({8'h0, mk_d(12'h123, 2'd3, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1)}, 24); strobe(6, 0);
        shift_bits({mk_a(3'd6, 12'h800, 8'h10), 8'h3C}, 32); strobe(8, 0);
        cur_req = "R6"; shift_bits({8'h0, mk_b(4'd3, 8'h55, 4'd15, 2'd3, 2'd2)}, 24); strobe(6, 0);
        shift_bits({mk_a(3'd2, 12'h0F0, 8'h44), 8'hE1}, 32); strobe(6, 0); // R6 long scale byte wins
        cur_req = "R9"; shift_bits({8'h0, mk_a(3'd7, 12'hFFF, 8'hFF)}, 24); strobe(6, 0);
        shift_bits({8'h0, mk_b(4'd1, 8'h01, 4'd1, 2'd1, 2'd1)}, 23); strobe(6, 0);
        shift_bits({8'h0, mk_a(3'd4, 12'h00F, 8'h0F)}, 24); strobe(6, 0); // R9 stage dropped
        shift_bits({7'h0, 1'b1, mk_d(12'hFFF, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0)}, 25); strobe(6, 0);
        cur_req = "R10"; shift_bits({8'h0, 4'b1011, 20'hFFFFF}, 24); strobe(6, 0);
        shift_bits({8'h0, 4'b1100, 20'h12345}, 24); strobe(6, 0);
        cur_req = "R8"; shift_bits({8'h0, mk_c(12'hA5A, 8'h00)}, 24); strobe(6, 3);
        shift_bits({8'h0, mk_c(12'h2D7, 8'hFF)}, 24); strobe(6, 0);
        cur_req = "R4"; shift_bits({8'h0, mk_d(12'h003, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0)}, 24); strobe(6, 0);
        shift_bits({8'h0, mk_a(3'd7, 12'hFFF, 8'hFF)}, 24); strobe(6, 0);
        idle(6);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule